// File: doc/BRIEF.md
# Generalized Reverse / OR-Combine / Shuffle Unit

This block is a 64-bit bit-permutation datapath for a scalar integer pipeline. A staged butterfly network carries out four operations, picked by an operation select:

- **Generalized reverse:** each set control bit k exchanges neighbouring groups of 2^k bits.
- **Generalized OR-combine:** the same exchanges, but each one is ORed into the running value.
- **Zip shuffle:** each enabled stage exchanges the middle two quarters of every 2^(k+2)-bit block.
- **Unzip unshuffle:** the zip stages applied in the opposite order.

The control value may come from a register or from an immediate field. A word-mode flag limits the operation to the low 32 bits of the operand and sign-extends the 32-bit result.

The result is registered, so it appears one clock after the operand, control, select and mode are presented. A fresh operation may be issued on every cycle.

Top module: `bperm_unit`

## Requirements
- R1: While reset is asserted, and after it is released until the first operation is captured, `res_o` reads zero.
- R2: `res_o` shows the result of the inputs sampled at the previous rising clock edge, and a new operation is accepted on every cycle.
- R3: With `op_i`=0 (reverse), control bit k (k=0..5) swaps each pair of adjacent 2^k-bit groups. Output bit i equals input bit (i XOR ctrl).
- R4: With `op_i`=1 (OR-combine), each enabled stage ORs the group-swapped value into the running value. Output bit i is the OR of input bits i XOR m, over every m whose set bits all lie in the control value.
- R5: With `op_i`=2 (zip), stages run in the order shift 16, 8, 4, 2, 1, and stage shift 2^k is enabled by control bit k. A stage with shift 2^k exchanges bit positions k and k+1 of every bit index.
- R6: With `op_i`=3 (unzip), the same stages run in the order shift 1, 2, 4, 8, 16. Unzip with a given control value undoes zip with that value.
- R7: In 64-bit mode, reverse and OR-combine use `ctrl_i[5:0]`. Zip and unzip use `ctrl_i[4:0]`, and `ctrl_i[5]` has no effect on them.
- R8: With `word_i`=1, reverse and OR-combine use `ctrl_i[4:0]`, and zip and unzip use `ctrl_i[3:0]`. Only the low 32 operand bits affect the result, and `res_o[63:32]` repeats `res_o[31]`.
- R9: Reverse with control 63 in 64-bit mode reverses the whole operand, so bit 0 moves to bit 63.
- R10: OR-combine with control 7 in 64-bit mode gives 0xFF in every byte that has any bit set, and 0x00 in every other byte.
- R11: An effective control value of zero passes the operand through unchanged in 64-bit mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| opnd_i | input | 64 | Operand to permute |
| ctrl_i | input | 6 | Control value from a register or an immediate |
| op_i | input | 2 | 0 reverse, 1 OR-combine, 2 zip, 3 unzip |
| word_i | input | 1 | 1 selects 32-bit word mode |
| res_o | output | 64 | Registered result |

## Verification
The assertions check properties that every cycle must satisfy:

- Word results always carry a sign-extended upper half.
- In 64-bit mode, reverse, zip and unzip preserve the number of set bits.
- OR-combine never clears an operand bit.
- A zero effective control value returns the operand unchanged.
- The output is zero throughout reset.

None of these show that bits land in the right positions. Exact placement, the stage ordering that tells zip from unzip, the masking of the control value in each mode, and the full-reverse and byte-mask corner values are shown only by the bench scenarios. The bench compares each result against an index-permutation model of its own.

// File: rtl/bperm_pkg.sv
package bperm_pkg;

  localparam int XLEN = 64;
  localparam int LG   = $clog2(XLEN);   // reverse / OR-combine stages
  localparam int HW   = XLEN / 2;
  localparam int ZS   = LG - 1;         // shuffle stages

  typedef enum logic [1:0] {
    OP_REV   = 2'd0,
    OP_ORC   = 2'd1,
    OP_ZIP   = 2'd2,
    OP_UNZIP = 2'd3
  } bperm_op_e;

  // Bits whose index has bit k clear: the lower member of each group pair.
  function automatic logic [XLEN-1:0] pair_lo_mask(int k);
    logic [XLEN-1:0] m;
    for (int i = 0; i < XLEN; i++) m[i] = ((i >> k) & 1) == 0;
    return m;
  endfunction

  // Quarter-select mask of a zip stage: quarter q (1 or 2) of each 2^(k+2) block.
  function automatic logic [XLEN-1:0] zip_quarter_mask(int k, int q);
    logic [XLEN-1:0] m;
    for (int i = 0; i < XLEN; i++) m[i] = ((i >> k) & 3) == q;
    return m;
  endfunction

  function automatic logic [XLEN-1:0] rev_stage(logic [XLEN-1:0] x, int k);
    logic [XLEN-1:0] m;
    m = pair_lo_mask(k);
    return ((x & m) << (1 << k)) | ((x & ~m) >> (1 << k));
  endfunction

  function automatic logic [XLEN-1:0] zip_stage(logic [XLEN-1:0] x, int k);
    logic [XLEN-1:0] ml, mr;
    ml = zip_quarter_mask(k, 2);
    mr = zip_quarter_mask(k, 1);
    return (x & ~(ml | mr)) | ((x << (1 << k)) & ml) | ((x >> (1 << k)) & mr);
  endfunction

endpackage

// File: rtl/bperm_butterfly.sv
module bperm_butterfly
  import bperm_pkg::*;
(
  input  logic [XLEN-1:0] din,
  input  logic [LG-1:0]   ctrl,
  input  logic            orc,
  output logic [XLEN-1:0] dout
);

  logic [XLEN-1:0] lvl [0:LG];

  assign lvl[0] = din;

  for (genvar k = 0; k < LG; k++) begin : g_stage
    logic [XLEN-1:0] swapped;
    assign swapped    = rev_stage(lvl[k], k);
    assign lvl[k+1]   = !ctrl[k] ? lvl[k] : (orc ? (lvl[k] | swapped) : swapped);
  end

  assign dout = lvl[LG];

endmodule

// File: rtl/bperm_shuffle.sv
module bperm_shuffle
  import bperm_pkg::*;
(
  input  logic [XLEN-1:0] din,
  input  logic [ZS-1:0]   ctrl,
  input  logic            unzip,
  output logic [XLEN-1:0] dout
);

  logic [XLEN-1:0] lvl [0:ZS];

  assign lvl[0] = din;

  // Position j runs stage j for unzip and stage ZS-1-j for zip.
  for (genvar j = 0; j < ZS; j++) begin : g_stage
    localparam int KU = j;
    localparam int KZ = ZS - 1 - j;
    logic [XLEN-1:0] via_u, via_z;
    assign via_u    = ctrl[KU] ? zip_stage(lvl[j], KU) : lvl[j];
    assign via_z    = ctrl[KZ] ? zip_stage(lvl[j], KZ) : lvl[j];
    assign lvl[j+1] = unzip ? via_u : via_z;
  end

  assign dout = lvl[ZS];

endmodule

// File: rtl/bperm_unit.sv
module bperm_unit
  import bperm_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [63:0]     opnd_i,
  input  logic [5:0]      ctrl_i,
  input  logic [1:0]      op_i,
  input  logic            word_i,
  output logic [63:0]     res_o
);

  bperm_op_e       op;
  logic [LG-1:0]   ctrl_bf;     // effective reverse / OR-combine control
  logic [ZS-1:0]   ctrl_sh;     // effective shuffle control
  logic [XLEN-1:0] bf_out, sh_out, full_res, next_res;
  logic            ctrl_is_zero;

  assign op = bperm_op_e'(op_i);

  assign ctrl_bf = word_i ? {1'b0, ctrl_i[LG-2:0]} : ctrl_i;
  assign ctrl_sh = word_i ? {1'b0, ctrl_i[ZS-2:0]} : ctrl_i[ZS-1:0];

  assign ctrl_is_zero = (op == OP_REV || op == OP_ORC) ? (ctrl_bf == '0)
                                                       : (ctrl_sh == '0);

  bperm_butterfly u_bfly (
    .din  (opnd_i),
    .ctrl (ctrl_bf),
    .orc  (op == OP_ORC),
    .dout (bf_out)
  );

  bperm_shuffle u_shuf (
    .din   (opnd_i),
    .ctrl  (ctrl_sh),
    .unzip (op == OP_UNZIP),
    .dout  (sh_out)
  );

  assign full_res = (op == OP_REV || op == OP_ORC) ? bf_out : sh_out;
  assign next_res = word_i ? {{HW{full_res[HW-1]}}, full_res[HW-1:0]} : full_res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_o <= '0;
    else        res_o <= next_res;
  end

  // Assertions
  always_comb begin
    if (!rst_n) AST_RESET_ZERO: assert (res_o == '0);  // R1
  end

  AST_WORD_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
    word_i |=> (res_o[63:32] == {32{res_o[31]}}));  // R8

  AST_PERM_POPCOUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!word_i && op != OP_ORC) |=> ($countones(res_o) == $countones($past(opnd_i))));  // R3

  AST_ORC_SUPERSET: assert property (@(posedge clk) disable iff (!rst_n)
    (!word_i && op == OP_ORC) |=> ((res_o & $past(opnd_i)) == $past(opnd_i)));  // R4

  AST_ZERO_CTRL_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!word_i && ctrl_is_zero) |=> (res_o == $past(opnd_i)));  // R11

endmodule

// File: tb/sim_bperm_unit.sv
module sim_bperm_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] opnd_i = '0;
  logic [5:0]  ctrl_i = '0;
  logic [1:0]  op_i = '0;
  logic        word_i = 1'b0;
  logic [63:0] res_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bperm_unit u0 (
    .clk(clk), .rst_n(rst_n), .opnd_i(opnd_i), .ctrl_i(ctrl_i),
    .op_i(op_i), .word_i(word_i), .res_o(res_o)
  );

  function automatic int swp(int i, int k);
    int a, b;
    a = (i >> k) & 1;
    b = (i >> (k + 1)) & 1;
    return (a != b) ? (i ^ (3 << k)) : i;
  endfunction

  function automatic logic [63:0] model(logic [1:0] op, logic [5:0] c_in,
                                        logic wm, logic [63:0] x);
    int c;
    logic [63:0] y, t;
    c = c_in;
    if (op < 2) c = c & (wm ? 31 : 63);
    else        c = c & (wm ? 15 : 31);
    y = '0;
    case (op)
      2'd0: for (int i = 0; i < 64; i++) y[i] = x[i ^ c];
      2'd1: for (int i = 0; i < 64; i++)
              for (int m = 0; m < 64; m++)
                if ((m & ~c) == 0) y[i] = y[i] | x[i ^ m];
      default: begin
        y = x;
        for (int s = 0; s < 5; s++) begin
          int k;
          k = (op == 2'd2) ? (4 - s) : s;
          if (((c >> k) & 1) != 0) begin
            t = y;
            for (int i = 0; i < 64; i++) y[i] = t[swp(i, k)];
          end
        end
      end
    endcase
    if (wm) y = {{32{y[31]}}, y[31:0]};
    return y;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Drive at negedge, compare one cycle later at the next negedge (R2).
  task automatic run(string tag, logic [1:0] op, logic [5:0] c,
                     logic wm, logic [63:0] x);
    logic [63:0] e;
    opnd_i = x; ctrl_i = c; op_i = op; word_i = wm;
    e = model(op, c, wm, x);
    @(negedge clk);
    check(tag, res_o, e);
  endtask

  task automatic run_lit(string tag, logic [1:0] op, logic [5:0] c,
                         logic wm, logic [63:0] x, logic [63:0] e);
    opnd_i = x; ctrl_i = c; op_i = op; word_i = wm;
    @(negedge clk);
    check(tag, res_o, e);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] z, v;
    repeat (3) @(negedge clk);
    check("R1 reset", res_o, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", res_o, 64'h0);

    run_lit("R9 full reverse", 2'd0, 6'd63, 1'b0, 64'h1, 64'h8000_0000_0000_0000);
    run_lit("R10 byte any-set", 2'd1, 6'd7, 1'b0,
            64'h0001_0000_8000_0200, 64'h00FF_0000_FF00_FF00);
    run_lit("R11 zero ctrl rev", 2'd0, 6'd0, 1'b0, 64'hDEAD_BEEF_0123_4567,
            64'hDEAD_BEEF_0123_4567);
    run_lit("R3 swap nibbles", 2'd0, 6'd4, 1'b0, 64'h0123_4567_89AB_CDEF,
            64'h1032_5476_98BA_DCFE);
    run_lit("R5 zip halves", 2'd2, 6'd16, 1'b0, 64'h1111_2222_3333_4444,
            64'h1111_3333_2222_4444);
    run_lit("R7 bit5 ignored zip", 2'd2, 6'd48, 1'b0, 64'h1111_2222_3333_4444,
            64'h1111_3333_2222_4444);
    run_lit("R8 word reverse", 2'd0, 6'd63, 1'b1, 64'hFFFF_FFFF_0000_0001,
            64'hFFFF_FFFF_8000_0000);
    run("R4 orc pairs", 2'd1, 6'd1, 1'b0, 64'h8421_0000_1248_0001);
    run("R6 unzip all", 2'd3, 6'd31, 1'b0, 64'h0123_4567_89AB_CDEF);
    run("R8 word orc", 2'd1, 6'd63, 1'b1, 64'h0000_0000_0000_0010);

    // R6: unzip undoes zip, for several control values.
    for (int c = 0; c < 32; c += 5) begin
      v = 64'hA5C3_0F1E_7B92_4D86 ^ (64'(c) * 64'h0101_0101_0101_0101);
      opnd_i = v; ctrl_i = 6'(c); op_i = 2'd2; word_i = 1'b0;
      @(negedge clk);
      z = res_o;
      check("R5 zip", z, model(2'd2, 6'(c), 1'b0, v));
      run_lit("R6 round trip", 2'd3, 6'(c), 1'b0, z, v);
    end

    // Random traffic, every cycle compared (R2..R8).
    for (int n = 0; n < 400; n++) begin
      logic [1:0] op;
      op = 2'($urandom_range(0, 3));
      run(op == 0 ? "R3 rev" : op == 1 ? "R4 orc" : op == 2 ? "R5 zip" : "R6 unzip",
          op, 6'($urandom), 1'($urandom), {$urandom, $urandom});
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule